// File: doc/BRIEF.md
# External Chip Clock Synchronizer

This block paces the chip stream of a direct-sequence transmitter. It runs on the transmit master clock. Each cycle it produces a chip-enable strobe that advances a spreading-code generator and a differential encoder. A single control field picks where that strobe comes from. One choice is an integer divider of the master clock. The other is an asynchronous pulse supplied from outside the chip, used when the needed chip rate is not an integer fraction of the master clock.

In external mode, the incoming pulse passes through a two-flop synchronizer and then an edge-detect register. Only a low-to-high transition produces a strobe. The pipeline depth is fixed, so the chip output always changes on the third rising master-clock edge after the external rising edge. A 4-bit maximal-length shift register stands in for the spreading code. Its output bit is combined with a differentially encoded data bit to give the observable chip. The external pulse is allowed to arrive as often as once every two master cycles.

Top module: `chip_pace_top`

## Requirements
- R1: An asynchronous active-low reset puts the block in a known state. The synchronizer, edge detector and divider are cleared. The source select returns to divided mode. The shift register is loaded with 4'b0001. The encoder bit and chip index are cleared. While reset is held, `chip_o` is 0 and `chip_stb_o` is 0.
- R2: A configuration write (`cfg_we_i` high at a clock edge) to address 7'h40 copies `cfg_data_i[2]` into the source select, where 1 means external and 0 means divided. The new source governs `chip_stb_o` from the next cycle onward. A write to any other address leaves the source unchanged.
- R3: In divided mode, `chip_stb_o` is high for exactly one cycle in every DIV_RATIO cycles (default 4). Activity on `ext_chip_i` has no effect in this mode.
- R4: In external mode, each rising edge of `ext_chip_i` yields exactly one single-cycle strobe. A steady high level and a falling edge yield none. Pulses that are one cycle high and one cycle low each yield their own strobe.
- R5: In external mode, if `ext_chip_i` rises between clock edges, `chip_stb_o` is high in the cycle after the second following rising clock edge. `chip_o` takes its new value on the third following rising edge.
- R6: On each strobe, the shift register q steps to {q[2:0], q[3]^q[2]}. `chip_o` equals q[3] XOR the encoder bit.
- R7: A chip index counts strobes from 0 to 14. On the strobe taken when the index is 14, the encoder bit is XORed with `tx_data_i` and the index wraps to 0.
- R8: In cycles without a strobe, the shift register, index, encoder bit and `chip_o` all hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 7 | Configuration register address |
| cfg_data_i | input | 8 | Configuration write data |
| ext_chip_i | input | 1 | Asynchronous external chip pulse |
| tx_data_i | input | 1 | Data bit folded in at each code-period boundary |
| chip_stb_o | output | 1 | One-cycle chip-enable strobe |
| chip_o | output | 1 | Spread and differentially encoded chip |

## Verification
Some properties are checked by assertions on every cycle:
- an external strobe is never wider than one cycle;
- an external strobe always traces back to a low-then-high input two and three cycles earlier;
- the divider strobe is never repeated on consecutive cycles;
- the source select moves only on a write to its address;
- the code state and `chip_o` move only after a strobe;
- the encoder bit flips only at the period boundary.

Other behaviour only the bench scenarios can show. This includes the exact divider period, the shift-register sequence and its XOR with the encoder bit over several code periods, immunity to the external input in divided mode, and the reset values.

// File: rtl/chip_pace_pkg.sv
package chip_pace_pkg;

  localparam int unsigned CFG_AW = 7;
  localparam int unsigned CFG_DW = 8;

  typedef enum logic {
    SRC_DIVIDED  = 1'b0,
    SRC_EXTERNAL = 1'b1
  } chip_src_e;

endpackage

// File: rtl/chip_pace_rstsync.sv
module chip_pace_rstsync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_no = stage_q[1];

endmodule

// File: rtl/chip_pace_sync.sv
module chip_pace_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);

  logic meta_q, stab_q, last_q;
  logic meta_d, stab_d, last_d;

  always_comb begin
    meta_d = async_i;
    stab_d = meta_q;
    last_d = stab_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
      last_q <= last_d;
    end
  end

  assign rise_o = stab_q & ~last_q;

  // cycles since reset, so that $past never reaches into the reset window
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= 2'd0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R4

  AST_RISE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && rise_o) |-> ($past(async_i, 2) && !$past(async_i, 3))); // R5

endmodule

// File: rtl/chip_pace_div.sv
module chip_pace_div #(
  parameter int unsigned DIV_RATIO = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int unsigned CNT_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_RATIO - 1);

  generate
    if (DIV_RATIO <= 1) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_count
      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             wrap;

      always_comb begin
        wrap  = (cnt_q == CNT_LAST);
        cnt_d = wrap ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end

      assign tick_o = wrap;

      AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o); // R3
    end
  endgenerate

endmodule

// File: rtl/chip_pace_cfg.sv
module chip_pace_cfg
  import chip_pace_pkg::*;
#(
  parameter logic [CFG_AW-1:0] SEL_ADDR = 7'h40,
  parameter int unsigned       SEL_BIT  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [CFG_DW-1:0] data_i,
  output chip_src_e         src_o
);

  chip_src_e src_q, src_d;
  logic      hit;

  always_comb begin
    hit   = we_i && (addr_i == SEL_ADDR);
    src_d = src_q;
    if (hit) begin
      src_d = chip_src_e'(data_i[SEL_BIT]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= SRC_DIVIDED;
    end else begin
      src_q <= src_d;
    end
  end

  assign src_o = src_q;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^data_i;

  AST_SRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == SEL_ADDR) |=> $stable(src_q)); // R2

  AST_SRC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == SEL_ADDR) |=> (src_q == chip_src_e'($past(data_i[SEL_BIT])))); // R2

endmodule

// File: rtl/chip_pace_code.sv
module chip_pace_code #(
  parameter int unsigned      PN_W    = 4,
  parameter logic [PN_W-1:0]  PN_TAPS = 4'b1100,
  parameter logic [PN_W-1:0]  PN_SEED = 4'b0001
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic data_i,
  output logic chip_o
);

  localparam int unsigned     CODE_LEN = (1 << PN_W) - 1;
  localparam int unsigned     IDX_W    = PN_W;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CODE_LEN - 1);

  logic [PN_W-1:0]  lfsr_q, lfsr_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             denc_q, denc_d;
  logic             at_last;

  always_comb begin
    at_last = (idx_q == IDX_LAST);
    lfsr_d  = lfsr_q;
    idx_d   = idx_q;
    denc_d  = denc_q;
    if (step_i) begin
      lfsr_d = {lfsr_q[PN_W-2:0], ^(lfsr_q & PN_TAPS)};
      if (at_last) begin
        idx_d  = '0;
        denc_d = denc_q ^ data_i;
      end else begin
        idx_d  = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q <= PN_SEED;
      idx_q  <= '0;
      denc_q <= 1'b0;
    end else begin
      lfsr_q <= lfsr_d;
      idx_q  <= idx_d;
      denc_q <= denc_d;
    end
  end

  assign chip_o = lfsr_q[PN_W-1] ^ denc_q;

  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> ($stable(lfsr_q) && $stable(idx_q) && $stable(denc_q))); // R8

  AST_LFSR_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0); // R6

  AST_DENC_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (denc_q != $past(denc_q)) |-> ($past(step_i) && $past(idx_q) == IDX_LAST)); // R7

endmodule

// File: rtl/chip_pace_top.sv
module chip_pace_top
  import chip_pace_pkg::*;
#(
  parameter int unsigned       DIV_RATIO = 4,
  parameter logic [CFG_AW-1:0] SEL_ADDR  = 7'h40,
  parameter int unsigned       SEL_BIT   = 2,
  parameter int unsigned       PN_W      = 4,
  parameter logic [PN_W-1:0]   PN_TAPS   = 4'b1100,
  parameter logic [PN_W-1:0]   PN_SEED   = 4'b0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_data_i,
  input  logic              ext_chip_i,
  input  logic              tx_data_i,
  output logic              chip_stb_o,
  output logic              chip_o
);

  logic      rst_sync_n;
  logic      ext_rise;
  logic      div_tick;
  chip_src_e src;

  chip_pace_rstsync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  chip_pace_cfg #(
    .SEL_ADDR (SEL_ADDR),
    .SEL_BIT  (SEL_BIT)
  ) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .data_i (cfg_data_i),
    .src_o  (src)
  );

  chip_pace_sync u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .async_i (ext_chip_i),
    .rise_o  (ext_rise)
  );

  chip_pace_div #(
    .DIV_RATIO (DIV_RATIO)
  ) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .tick_o (div_tick)
  );

  always_comb begin
    chip_stb_o = (src == SRC_EXTERNAL) ? ext_rise : div_tick;
  end

  chip_pace_code #(
    .PN_W    (PN_W),
    .PN_TAPS (PN_TAPS),
    .PN_SEED (PN_SEED)
  ) u_code (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .step_i (chip_stb_o),
    .data_i (tx_data_i),
    .chip_o (chip_o)
  );

  AST_CHIP_NEEDS_STB: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (chip_o != $past(chip_o)) |-> $past(chip_stb_o)); // R8

  AST_EXT_NO_DIV: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (src == SRC_EXTERNAL && chip_stb_o) |-> $past(ext_chip_i, 2)); // R5

endmodule

// File: tb/tb_chip_pace_top.sv
module tb_chip_pace_top;

  localparam int DIV  = 4;
  localparam int CLEN = 15;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [6:0] cfg_addr;
  logic [7:0] cfg_data;
  logic       ext;
  logic       dat;
  logic       stb;
  logic       chip;

  always #4 clk = ~clk;

  chip_pace_top #(.DIV_RATIO(DIV)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_we_i   (cfg_we),
    .cfg_addr_i (cfg_addr),
    .cfg_data_i (cfg_data),
    .ext_chip_i (ext),
    .tx_data_i  (dat),
    .chip_stb_o (stb),
    .chip_o     (chip)
  );

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [3:0] m_lfsr;
  int         m_idx;
  logic       m_denc;
  logic       m_mode;
  logic       h1, h2, h3;
  bit         locked;
  int         icnt;
  int         prev_kind; // 0 none, 1 strobe, 2 strobe at wrap

  // {mode, data, high cycles, low cycles}
  localparam logic [9:0] VEC [0:17] = '{
    {1'b1, 1'b0, 4'd1, 4'd1}, {1'b1, 1'b0, 4'd1, 4'd2}, {1'b1, 1'b1, 4'd3, 4'd1},
    {1'b1, 1'b0, 4'd5, 4'd4}, {1'b1, 1'b1, 4'd2, 4'd2}, {1'b0, 4'd0, 4'd0, 4'd6} [9:0],
    {1'b0, 1'b1, 4'd1, 4'd1}, {1'b0, 1'b0, 4'd2, 4'd3}, {1'b0, 1'b1, 4'd7, 4'd2},
    {1'b1, 1'b1, 4'd1, 4'd1}, {1'b1, 1'b1, 4'd1, 4'd3}, {1'b1, 1'b0, 4'd4, 4'd1},
    {1'b1, 1'b1, 4'd1, 4'd1}, {1'b1, 1'b0, 4'd2, 4'd5}, {1'b0, 1'b1, 4'd3, 4'd3},
    {1'b0, 1'b0, 4'd1, 4'd8}, {1'b1, 1'b0, 4'd1, 4'd1}, {1'b1, 1'b1, 4'd6, 4'd6}
  };

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lfsr    = 4'b0001;
    m_idx     = 0;
    m_denc    = 1'b0;
    m_mode    = 1'b0;
    h1 = 1'b0; h2 = 1'b0; h3 = 1'b0;
    locked    = 1'b0;
    icnt      = 0;
    prev_kind = 0;
  endtask

  // called at a falling edge: check, drive, then update the model for the next edge
  task automatic step(input bit e, input bit d, input bit we = 1'b0,
                      input logic [6:0] a = 7'h00, input logic [7:0] wd = 8'h00);
    bit    exp_s;
    bit    have;
    logic  exp_chip;
    string chip_req;
    have  = 1'b1;
    exp_s = 1'b0;
    if (m_mode) begin
      exp_s = h2 & ~h3;
      chk(stb === exp_s, exp_s ? "R5" : "R4", stb, exp_s);
    end else if (locked) begin
      exp_s = (icnt == DIV - 1);
      chk(stb === exp_s, "R3", stb, exp_s);
    end else begin
      have = 1'b0;
      if (stb === 1'b1) begin
        exp_s  = 1'b1;
        locked = 1'b1;
        icnt   = DIV - 1;
      end
    end
    exp_chip = m_lfsr[3] ^ m_denc;
    chip_req = (prev_kind == 2) ? "R7" : ((prev_kind == 1) ? "R6" : "R8");
    chk(chip === exp_chip, chip_req, chip, exp_chip);

    ext = e; dat = d; cfg_we = we; cfg_addr = a; cfg_data = wd;
    h3 = h2; h2 = h1; h1 = e;
    prev_kind = 0;
    if (exp_s) begin
      prev_kind = (m_idx == CLEN - 1) ? 2 : 1;
      m_lfsr = {m_lfsr[2:0], m_lfsr[3] ^ m_lfsr[2]};
      if (m_idx == CLEN - 1) begin
        m_idx  = 0;
        m_denc = m_denc ^ d;
      end else begin
        m_idx++;
      end
    end
    if (locked) icnt = (icnt + 1) % DIV;
    if (we && a == 7'h40) m_mode = wd[2];
    if (!have) begin end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0; ext = 1'b0; dat = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    chk(chip === 1'b0, "R1", chip, 0);
    chk(stb === 1'b0, "R1", stb, 0);
    rst_n = 1'b1;
    repeat (12) step(1'b0, 1'b0);
    chk(locked == 1'b1, "R3", locked, 1);

    // table walk
    for (int v = 0; v < 18; v++) begin
      logic vm, vd;
      int   hi, lo;
      vm = VEC[v][9]; vd = VEC[v][8]; hi = VEC[v][7:4]; lo = VEC[v][3:0];
      if (vm != m_mode) step(1'b0, vd, 1'b1, 7'h40, {5'b0, vm, 2'b0});
      for (int c = 0; c < hi; c++) step(1'b1, vd);
      for (int c = 0; c < lo; c++) step(1'b0, vd);
    end

    // fast pulse train with data 1: crosses code-period boundaries
    if (!m_mode) step(1'b0, 1'b1, 1'b1, 7'h40, 8'h04);
    step(1'b0, 1'b1);
    for (int p = 0; p < 40; p++) begin
      step(1'b1, 1'b1);
      step(1'b0, 1'b1);
    end

    // write to a neighbouring address must not leave external mode
    step(1'b0, 1'b0, 1'b1, 7'h41, 8'h00);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    chk(stb === 1'b1, "R2", stb, 1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);

    // clear the select bit with other bits set: divided mode, pulses ignored
    step(1'b0, 1'b1, 1'b1, 7'h40, 8'hFB);
    for (int p = 0; p < 30; p++) begin
      step(p[0], 1'b1);
    end
    // long quiet stretch in external mode
    step(1'b0, 1'b0, 1'b1, 7'h40, 8'hFF);
    repeat (20) step(1'b0, 1'b0);

    // mid-run reset
    rst_n = 1'b0;
    #1;
    chk(chip === 1'b0, "R1", chip, 0);
    chk(stb === 1'b0, "R1", stb, 0);
    ext = 1'b0;
    repeat (3) @(negedge clk);
    chk(chip === 1'b0, "R1", chip, 0);
    rst_n = 1'b1;
    model_reset();
    repeat (10) step(1'b0, 1'b0);
    for (int p = 0; p < 6; p++) begin
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
    end
    repeat (4) step(1'b0, 1'b0);

    report();
    $finish;
  end

endmodule